// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block switches byte channels between serial time-division-multiplexed streams. Several serial input streams share one frame timing. Each frame carries a fixed number of eight-bit channels per stream, sent most significant bit first. Every received byte is stored, and every output channel is rebuilt from a per-channel connection entry. The entry makes the output channel do one of four things: take any stored input channel, send a fixed byte held in the entry, release the line (output enable low), or drive every bit high.

Stored data is kept in three frame-sized banks used in rotation. Each output therefore always reads data that arrived exactly two frames earlier, whatever the source and destination channel numbers are. A host port writes and reads the connection entries one at a time. It also offers a fill command that loads one value into every entry, one entry per clock. With the default parameters there are 8 streams of 16 channels, so one frame lasts 128 clocks at one bit per clock. The connection memory then holds 128 entries of 10 bits.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_ni` is low and after its release, `sto_o`, `sto_oe_o` and `cm_busy_o` are zero and every connection entry reads back as zero.
- R2: A high `fp_i` marks frame bit 0 in that clock; otherwise the bit position advances by one per clock and wraps after N_CH*8 positions. Bit position p carries bit 7-(p mod 8) of channel p/8. Each output bit appears one clock after the input bit at the same frame position.
- R3: In switch mode (entry bits [9:8] = 0), output channel c of a stream carries the byte received two frames earlier on source stream entry[6:4], channel entry[3:0]. No frame-count lag depends on the channel numbers. Data not yet received reads as zero.
- R4: Switching is non-blocking: any output channel may take any input channel, and one input channel may feed many outputs at the same time.
- R5: In message mode (bits [9:8] = 1), the output channel sends entry[7:0] MSB first with its enable high.
- R6: In release mode (bits [9:8] = 2), the output channel's enable is low and its data is 0.
- R7: In drive-high mode (bits [9:8] = 3), the output channel sends all ones with its enable high.
- R8: While `odis_i` is high, every bit of `sto_oe_o` is low in the same clock, whatever the entries say.
- R9: A host write (`cm_we_i`) stores `cm_wdata_i` at entry `cm_addr_i` = {stream[6:4], channel[3:0]}. The new entry takes effect from the next clock. `cm_rdata_o` shows the entry at `cm_addr_i` combinationally.
- R10: A `cm_fill_i` pulse while idle raises `cm_busy_o` for exactly 128 clocks (one per entry), writing the captured `cm_wdata_i` into entries 0 upward. A fill that coincides with a write wins over the write.
- R11: While `cm_busy_o` is high, `cm_we_i` and `cm_fill_i` have no effect. When the fill ends, every entry holds the fill value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_i | input | 1 | Frame start, high in the clock of frame bit 0 |
| sti_i | input | N_ST | Serial input streams |
| odis_i | input | 1 | Global output disable |
| cm_we_i | input | 1 | Host entry write strobe |
| cm_fill_i | input | 1 | Host fill command |
| cm_addr_i | input | LOC_W | Host entry address {stream, channel} |
| cm_wdata_i | input | ENT_W | Host write / fill value |
| cm_rdata_o | output | ENT_W | Entry at cm_addr_i |
| cm_busy_o | output | 1 | Fill in progress |
| sto_o | output | N_ST | Serial output streams |
| sto_oe_o | output | N_ST | Per-stream output enable for the current bit |

## Verification
A bank rotation that slips or a read bank that equals the write bank shows on the outputs within the third frame after reset. The switched bytes then come out one frame early or late, or mixed with bytes of the current frame. A wrong entry decode or a wrong bit index shows in the very first channel that uses it, within one clock. A fill address that skips or stops early shows first as a wrong busy length, and later as stale readback or wrong output bytes in the next frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic [1:0] {
    MODE_SWITCH = 2'd0,
    MODE_MSG    = 2'd1,
    MODE_HIZ    = 2'd2,
    MODE_HIGH   = 2'd3
  } out_mode_e;
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer #(
  parameter int CH_W = 4,
  localparam int FB_W = CH_W + 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fp_i,
  output logic [FB_W-1:0] pos_o,
  output logic [1:0]      wr_bank_o,
  output logic [1:0]      rd_bank_o
);
  logic [FB_W-1:0] pos_q;
  logic [1:0]      wr_q;
  logic            frame_last;

  assign pos_o      = fp_i ? '0 : pos_q;
  assign frame_last = &pos_o;
  assign wr_bank_o  = wr_q;
  // bank written two frames ago == next bank in rotation
  assign rd_bank_o  = (wr_q == 2'd2) ? 2'd0 : wr_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      wr_q  <= '0;
    end else begin
      pos_q <= pos_o + 1'b1;
      if (frame_last) wr_q <= (wr_q == 2'd2) ? 2'd0 : wr_q + 2'd1;
    end
  end

  assert_bank_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last |=> wr_q != $past(wr_q));
  assert_bank_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_last |=> $stable(wr_q));
  assert_bank_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q != 2'd3);
endmodule

// File: rtl/tsi_rx_store.sv
module tsi_rx_store #(
  parameter int N_ST = 8,
  parameter int N_CH = 16,
  localparam int ST_W  = $clog2(N_ST),
  localparam int CH_W  = $clog2(N_CH),
  localparam int LOC_W = ST_W + CH_W,
  localparam int N_LOC = N_ST * N_CH,
  localparam int FB_W  = CH_W + 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_ST-1:0]             sti_i,
  input  logic [FB_W-1:0]             pos_i,
  input  logic [1:0]                  wr_bank_i,
  input  logic [1:0]                  rd_bank_i,
  input  logic [N_ST-1:0][LOC_W-1:0]  rd_loc_i,
  output logic [N_ST-1:0][7:0]        rd_byte_o
);
  logic [6:0] sh_q [N_ST];
  logic [7:0] dm_q [3][N_LOC];
  logic [CH_W-1:0] ch;
  logic            last_bit;

  assign ch       = pos_i[FB_W-1:3];
  assign last_bit = &pos_i[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 3; b++)
        for (int l = 0; l < N_LOC; l++) dm_q[b][l] <= '0;
      for (int s = 0; s < N_ST; s++) sh_q[s] <= '0;
    end else begin
      for (int s = 0; s < N_ST; s++) begin
        sh_q[s] <= {sh_q[s][5:0], sti_i[s]};
        if (last_bit) dm_q[wr_bank_i][{ST_W'(s), ch}] <= {sh_q[s], sti_i[s]};
      end
    end
  end

  always_comb begin
    for (int s = 0; s < N_ST; s++) rd_byte_o[s] = dm_q[rd_bank_i][rd_loc_i[s]];
  end

  assert_bank_apart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_bank_i != wr_bank_i);
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
  parameter int N_ST  = 8,
  parameter int LOC_W = 7,
  parameter int ENT_W = 10,
  localparam int N_LOC = 1 << LOC_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        fill_i,
  input  logic [LOC_W-1:0]            addr_i,
  input  logic [ENT_W-1:0]            wdata_i,
  input  logic [N_ST-1:0][LOC_W-1:0]  rd_loc_i,
  output logic [N_ST-1:0][ENT_W-1:0]  ent_o,
  output logic [ENT_W-1:0]            host_rdata_o,
  output logic                        busy_o
);
  logic [ENT_W-1:0] cm_q [N_LOC];
  logic             busy_q;
  logic [LOC_W-1:0] fill_addr_q;
  logic [ENT_W-1:0] fill_val_q;

  assign busy_o       = busy_q;
  assign host_rdata_o = cm_q[addr_i];

  always_comb begin
    for (int s = 0; s < N_ST; s++) ent_o[s] = cm_q[rd_loc_i[s]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < N_LOC; l++) cm_q[l] <= '0;
      busy_q      <= 1'b0;
      fill_addr_q <= '0;
      fill_val_q  <= '0;
    end else if (busy_q) begin
      cm_q[fill_addr_q] <= fill_val_q;
      fill_addr_q       <= fill_addr_q + 1'b1;
      if (&fill_addr_q) busy_q <= 1'b0;
    end else if (fill_i) begin
      busy_q      <= 1'b1;
      fill_addr_q <= '0;
      fill_val_q  <= wdata_i;
    end else if (we_i) begin
      cm_q[addr_i] <= wdata_i;
    end
  end

  assert_fill_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> fill_addr_q == '0);
  assert_fill_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (&fill_addr_q) |=> !busy_q);
  assert_fill_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !(&fill_addr_q) |=> busy_q && fill_addr_q == $past(fill_addr_q) + 1'b1);
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane
  import tsi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] bit_i,
  input  logic [1:0] mode_i,
  input  logic [7:0] msg_i,
  input  logic [7:0] sw_byte_i,
  output logic       sto_o,
  output logic       oe_o
);
  out_mode_e  mode;
  logic [7:0] byte_sel;
  logic       d_nxt, oe_nxt;
  logic       sto_q, oe_q;

  assign mode     = out_mode_e'(mode_i);
  assign byte_sel = (mode == MODE_MSG) ? msg_i : sw_byte_i;

  always_comb begin
    unique case (mode)
      MODE_HIZ:  begin d_nxt = 1'b0; oe_nxt = 1'b0; end
      MODE_HIGH: begin d_nxt = 1'b1; oe_nxt = 1'b1; end
      default:   begin d_nxt = byte_sel[3'd7 - bit_i]; oe_nxt = 1'b1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sto_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sto_q <= d_nxt;
      oe_q  <= oe_nxt;
    end
  end

  assign sto_o = sto_q;
  assign oe_o  = oe_q;

  assert_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd2 |=> !oe_q && !sto_q);
  assert_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd3 |=> oe_q && sto_q);
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int N_ST = 8,
  parameter int N_CH = 16,
  localparam int ST_W  = $clog2(N_ST),
  localparam int CH_W  = $clog2(N_CH),
  localparam int LOC_W = ST_W + CH_W,
  localparam int PAY_W = (LOC_W > 8) ? LOC_W : 8,
  localparam int ENT_W = PAY_W + 2,
  localparam int FB_W  = CH_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic [N_ST-1:0]  sti_i,
  input  logic             odis_i,
  input  logic             cm_we_i,
  input  logic             cm_fill_i,
  input  logic [LOC_W-1:0] cm_addr_i,
  input  logic [ENT_W-1:0] cm_wdata_i,
  output logic [ENT_W-1:0] cm_rdata_o,
  output logic             cm_busy_o,
  output logic [N_ST-1:0]  sto_o,
  output logic [N_ST-1:0]  sto_oe_o
);
  logic [FB_W-1:0]             pos;
  logic [1:0]                  wr_bank, rd_bank;
  logic [N_ST-1:0][LOC_W-1:0]  out_loc;
  logic [N_ST-1:0][LOC_W-1:0]  src_loc;
  logic [N_ST-1:0][ENT_W-1:0]  ent;
  logic [N_ST-1:0][7:0]        sw_byte;
  logic [N_ST-1:0]             oe;

  tsi_frame_timer #(.CH_W(CH_W)) u_timer (
    .clk_i, .rst_ni, .fp_i,
    .pos_o(pos), .wr_bank_o(wr_bank), .rd_bank_o(rd_bank)
  );

  tsi_conn_mem #(.N_ST(N_ST), .LOC_W(LOC_W), .ENT_W(ENT_W)) u_cmem (
    .clk_i, .rst_ni,
    .we_i(cm_we_i), .fill_i(cm_fill_i), .addr_i(cm_addr_i), .wdata_i(cm_wdata_i),
    .rd_loc_i(out_loc), .ent_o(ent), .host_rdata_o(cm_rdata_o), .busy_o(cm_busy_o)
  );

  tsi_rx_store #(.N_ST(N_ST), .N_CH(N_CH)) u_store (
    .clk_i, .rst_ni, .sti_i, .pos_i(pos),
    .wr_bank_i(wr_bank), .rd_bank_i(rd_bank),
    .rd_loc_i(src_loc), .rd_byte_o(sw_byte)
  );

  for (genvar s = 0; s < N_ST; s++) begin : g_lane
    assign out_loc[s] = {ST_W'(s), pos[FB_W-1:3]};
    assign src_loc[s] = ent[s][LOC_W-1:0];

    tsi_tx_lane u_lane (
      .clk_i, .rst_ni,
      .bit_i(pos[2:0]),
      .mode_i(ent[s][ENT_W-1 -: 2]),
      .msg_i(ent[s][7:0]),
      .sw_byte_i(sw_byte[s]),
      .sto_o(sto_o[s]),
      .oe_o(oe[s])
    );
  end

  assign sto_oe_o = oe & ~{N_ST{odis_i}};
endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  localparam int NS = 8;
  localparam int NC = 16;
  localparam int NL = NS * NC;
  localparam int FBITS = NC * 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fp = 1'b0;
  logic [7:0]  sti = '0;
  logic        odis = 1'b0;
  logic        cm_we = 1'b0;
  logic        cm_fill = 1'b0;
  logic [6:0]  cm_addr = '0;
  logic [9:0]  cm_wdata = '0;
  logic [9:0]  cm_rdata;
  logic        cm_busy;
  logic [7:0]  sto, sto_oe;

  always #10 clk = ~clk;

  tsi_switch u0 (
    .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .sti_i(sti), .odis_i(odis),
    .cm_we_i(cm_we), .cm_fill_i(cm_fill), .cm_addr_i(cm_addr), .cm_wdata_i(cm_wdata),
    .cm_rdata_o(cm_rdata), .cm_busy_o(cm_busy), .sto_o(sto), .sto_oe_o(sto_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // reference model
  logic [9:0] mcm [NL];
  logic [7:0] hist [3][NS][NC];
  int         mpos, mframe, fa;
  bit         mbusy;
  logic [9:0] fv;
  logic [7:0] exp_d, exp_oe;
  int         exp_mode [NS];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) mcm[l] = '0;
      for (int b = 0; b < 3; b++)
        for (int s = 0; s < NS; s++)
          for (int c = 0; c < NC; c++) hist[b][s][c] = '0;
      mpos = 0; mframe = 0; mbusy = 0; fa = 0; fv = '0;
      exp_d = '0; exp_oe = '0;
      for (int s = 0; s < NS; s++) exp_mode[s] = 0;
    end else begin
      int p, ch, bi;
      p  = fp ? 0 : mpos;
      ch = p / 8;
      bi = p % 8;
      for (int s = 0; s < NS; s++) begin
        logic [9:0] e;
        logic [7:0] by;
        e = mcm[s * NC + ch];
        exp_mode[s] = int'(e[9:8]);
        by = (e[9:8] == 2'd1) ? e[7:0] : hist[(mframe + 1) % 3][e[6:4]][e[3:0]];
        case (e[9:8])
          2'd2:    begin exp_d[s] = 1'b0; exp_oe[s] = 1'b0; end
          2'd3:    begin exp_d[s] = 1'b1; exp_oe[s] = 1'b1; end
          default: begin exp_d[s] = by[7 - bi]; exp_oe[s] = 1'b1; end
        endcase
      end
      if (mbusy) begin
        mcm[fa] = fv;
        if (fa == NL - 1) mbusy = 0;
        fa = (fa + 1) % NL;
      end else if (cm_fill) begin
        mbusy = 1; fa = 0; fv = cm_wdata;
      end else if (cm_we) begin
        mcm[cm_addr] = cm_wdata;
      end
      for (int s = 0; s < NS; s++) hist[mframe % 3][s][ch][7 - bi] = sti[s];
      mpos = (p + 1) % FBITS;
      if (p == FBITS - 1) mframe++;
    end
  end

  function automatic string tag_of(int s);
    case (exp_mode[s])
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return (s == 0) ? "R3" : (s == 1) ? "R4" : "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    #5;
    if (cmp_en) begin
      for (int s = 0; s < NS; s++) begin
        logic eo;
        eo = exp_oe[s] & ~odis;
        chk(sto[s] === exp_d[s], tag_of(s), int'(sto[s]), int'(exp_d[s]));
        chk(sto_oe[s] === eo, odis ? "R8" : tag_of(s), int'(sto_oe[s]), int'(eo));
      end
      chk(cm_busy === mbusy, "R10", int'(cm_busy), int'(mbusy));
      chk(cm_rdata === mcm[cm_addr], "R9", int'(cm_rdata), int'(mcm[cm_addr]));
    end
  end

  // serial stimulus and frame pulse
  initial begin
    int bpos;
    logic [15:0] lfsr;
    bpos = 0;
    lfsr = 16'hACE1;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        bpos = 0; fp = 1'b0; sti = '0;
      end else begin
        fp   = (bpos == 0);
        sti  = lfsr[7:0] ^ lfsr[15:8];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bpos = (bpos + 1) % FBITS;
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  task automatic cm_write(int a, logic [9:0] d);
    @(negedge clk);
    cm_we = 1'b1; cm_addr = 7'(a); cm_wdata = d;
  endtask

  task automatic idle(int n);
    @(negedge clk);
    cm_we = 1'b0; cm_fill = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic fill_run(logic [9:0] v, bit poke);
    int cnt;
    @(negedge clk);
    cm_fill = 1'b1; cm_wdata = v; cm_we = 1'b0;
    @(negedge clk);
    cm_fill = 1'b0;
    cnt = 0;
    while (cm_busy === 1'b1 && cnt < 1000) begin
      if (poke && cnt < 5) begin
        cm_we = 1'b1; cm_addr = 7'(cnt * 3); cm_wdata = 10'h300;
      end else if (poke && cnt == 5) begin
        cm_we = 1'b0; cm_fill = 1'b1; cm_wdata = 10'h2FF;
      end else begin
        cm_we = 1'b0; cm_fill = 1'b0;
      end
      cnt++;
      @(negedge clk);
    end
    cm_we = 1'b0; cm_fill = 1'b0;
    chk(cnt == NL, "R10", cnt, NL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R1: state held in reset
    chk(sto === 8'h00, "R1", int'(sto), 0);
    chk(sto_oe === 8'h00, "R1", int'(sto_oe), 0);
    chk(cm_busy === 1'b0, "R1", int'(cm_busy), 0);
    chk(cm_rdata === 10'h000, "R1", int'(cm_rdata), 0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    cmp_en = 1'b1;
    #2;
    chk(sto === 8'h00 && sto_oe === 8'h00, "R1", int'({sto, sto_oe}), 0);

    for (int c = 0; c < NC; c++) begin
      cm_write(0 * NC + c, 10'((c % 8) << 4 | (15 - c)));      // R3 permutation
      cm_write(1 * NC + c, 10'((3 << 4) | 5));                 // R4 broadcast
      cm_write(2 * NC + c, 10'((1 << 8) | ((c * 17 + 3) & 8'hFF))); // R5 messages
      cm_write(3 * NC + c, (c % 2 == 0) ? 10'h200 : 10'h300);  // R6 / R7
      cm_write(5 * NC + c, 10'((5 << 4) | c));                 // R2 identity
    end
    idle(4 * FBITS);

    @(negedge clk); odis = 1'b1;      // R8
    repeat (40) @(negedge clk);
    odis = 1'b0;
    idle(FBITS);

    fill_run(10'h1A5, 1'b1);          // R10 / R11
    for (int a = 0; a < 16; a += 3) begin
      @(negedge clk);
      cm_addr = 7'(a);
      #2 chk(cm_rdata === 10'h1A5, "R11", int'(cm_rdata), 'h1A5);
    end
    idle(2 * FBITS);

    fill_run(10'((2 << 4) | 7), 1'b0);
    cm_write(4 * NC + 9, 10'h300);    // R9 write right after fill
    idle(3 * FBITS);

    @(negedge clk); odis = 1'b1;
    repeat (20) @(negedge clk);
    odis = 1'b0;
    idle(FBITS);
    finish_run();
  end
endmodule